// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that keeps a small bank of configuration bytes for a clock generator. A host on the bus loads the bytes with a block-write transfer and checks them with a block-read transfer. The whole bank appears at once on a parallel output, so downstream logic can use it directly.

The bus lines arrive asynchronously. The slave samples them on a much faster system clock. It finds start and stop conditions, matches the fixed write and read addresses, and pulls SDA low for acknowledge and for read data. The host never gives a register offset.

- **Write transfers.** The two bytes after the address are acknowledged and then dropped. Data always fills the bank from the lowest byte upward.
- **Read transfers.** The slave first sends the number of bytes in the bank, then the bytes themselves in the same order.

The slave never stretches the clock. It supports only one bus master and only 7-bit addressing. The bus runs at standard-mode rates.

Top module: `i2c_cfg_slave`

## Requirements
- R1: An address byte of D2h (write) or D3h (read) is acknowledged: the slave pulls SDA low for the ninth SCL clock of that byte.
- R2: Any other address byte gets no acknowledge. The slave does not drive SDA again until the next start condition, and `cfgBytes` does not change.
- R3: In a write, the first two bytes after the address are each acknowledged, and their contents are never stored.
- R4: In a write, the third and later bytes are acknowledged and stored in order into byte 0, byte 1, and so on. Byte k is at `cfgBytes[8k+7:8k]`.
- R5: A stop after any complete byte ends the write. The bytes received so far keep their new values, and every other byte keeps its previous value.
- R6: Data bytes that arrive after the last register byte in a write are acknowledged and discarded.
- R7: In a read, the first byte the slave sends, MSB first, is the register count (06h for the default of six bytes).
- R8: After the count, a read returns byte 0 upward while the host acknowledges. Past the last byte, the slave sends FFh. A host not-acknowledge ends the read, and SDA is released.
- R9: SCL and SDA pass through two-flop synchronizers. A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) in the middle of a byte drops the partial byte without changing any register. A start always begins a new address phase, and after either condition the slave releases SDA.
- R10: While reset is held, `cfgBytes` is FFFF_FFFF_FF00h (byte 0 is 00h, every other byte is FFh) and `sdaOe` is low.
- R11: The slave changes its SDA drive only in the cycle after a synchronized SCL fall or a start or stop condition. It never changes the drive while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| cfgBytes | output | 48 | Register bank, byte 0 in bits 7:0 |

## Verification
Two functions can meet in the same stretch of bus activity: a stop or a repeated start can arrive while a byte is still being shifted in or sent out. If the bytes are mishandled, a partial byte gets committed, or SDA stays pulled low across the new condition.

The bench provokes this with directed cases:
- a stop after four bits of a data byte;
- a repeated start after five bits of a data byte, followed at once by a read.

It judges the outcome by reading the whole bank back and comparing it with a bench model. It also watches `sdaOe` against the SCL level. Random write and read transfers of varied length, some running past the last register, are mixed between these cases.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SACK,
    ST_RX,
    ST_TX,
    ST_MACK
  } busState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic sampleBit;
    logic loadTx;
    logic shiftTx;
    logic commitByte;
  } dpStrobe_t;

  // datapath -> control bus events (synchronized domain)
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaNow;
  } busEvent_t;

endpackage

// File: rtl/i2c_cfg_dp.sv
module i2c_cfg_dp
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W = $clog2(NUM_BYTES + 3),
  parameter logic [NUM_BYTES*8-1:0] RESET_VALUE = {{(NUM_BYTES-1){8'hFF}}, 8'h00}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  input  dpStrobe_t              strobe,
  input  logic [IDX_W-1:0]       frameIdx,
  output busEvent_t              ev,
  output logic [7:0]             rxByte,
  output logic                   txBit,
  output logic [NUM_BYTES*8-1:0] cfgBytes
);

  // write slots 0 and 1 carry the ignored command and count bytes
  localparam int DATA_BASE = 2;

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;
  logic [7:0] txShift;
  logic [7:0] txSource;

  // input synchronizers, idle bus reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    ev.sclRise   = sclNow & ~sclPrev;
    ev.sclFall   = ~sclNow & sclPrev;
    ev.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sdaNow    = sdaNow;
  end

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (strobe.sampleBit) begin
      rxByte <= {rxByte[6:0], sdaNow};
    end
  end

  // read source: slot 0 is the count, then the bank, then all ones
  always_comb begin
    txSource = 8'hFF;
    if (frameIdx == '0) txSource = 8'(NUM_BYTES);
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (frameIdx == IDX_W'(i + 1)) txSource = cfgBytes[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= 8'hFF;
    end else if (strobe.loadTx) begin
      txShift <= txSource;
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign txBit = txShift[7];

  // register bank, written only by a committed byte in a data slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBytes <= RESET_VALUE;
    end else if (strobe.commitByte) begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (frameIdx == IDX_W'(i + DATA_BASE)) cfgBytes[i*8 +: 8] <= rxByte;
      end
    end
  end

endmodule

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int IDX_W = $clog2(NUM_BYTES + 3),
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic             clk,
  input  logic             rstN,
  input  busEvent_t        ev,
  input  logic [7:0]       rxByte,
  input  logic             txBit,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] frameIdx,
  output logic             sdaOe
);

  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);
  localparam int LAST_SLOT = NUM_BYTES + 2;

  busState_e state, nState;
  logic [CNT_W-1:0] bitCnt, nBit;
  logic [IDX_W-1:0] nIdx, idxNext;
  logic isRead, nRead;
  logic hostNack, nNack;
  logic byteFull;

  assign byteFull = (bitCnt == CNT_W'(BITS_PER_BYTE));
  assign idxNext  = (frameIdx == IDX_W'(LAST_SLOT)) ? frameIdx : frameIdx + 1'b1;

  always_comb begin
    nState = state;
    nBit   = bitCnt;
    nIdx   = frameIdx;
    nRead  = isRead;
    nNack  = hostNack;
    strobe = '0;
    if (ev.startSeen) begin
      nState = ST_ADDR;
      nBit   = '0;
      nIdx   = '0;
    end else if (ev.stopSeen) begin
      nState = ST_IDLE;
      nBit   = '0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (ev.sclRise && !byteFull) begin
            strobe.sampleBit = 1'b1;
            nBit = bitCnt + 1'b1;
          end else if (ev.sclFall && byteFull) begin
            nBit = '0;
            if (state == ST_ADDR) begin
              if (rxByte == WR_ADDR) begin
                nState = ST_SACK;
                nRead  = 1'b0;
              end else if (rxByte == RD_ADDR) begin
                nState = ST_SACK;
                nRead  = 1'b1;
              end else begin
                nState = ST_IDLE;
              end
            end else begin
              strobe.commitByte = 1'b1;
              nIdx   = idxNext;
              nState = ST_SACK;
            end
          end
        end
        ST_SACK: begin
          if (ev.sclFall) begin
            if (isRead) begin
              strobe.loadTx = 1'b1;
              nIdx   = idxNext;
              nState = ST_TX;
            end else begin
              nState = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev.sclRise) begin
            nBit = bitCnt + 1'b1;
          end else if (ev.sclFall) begin
            if (byteFull) begin
              nBit   = '0;
              nState = ST_MACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (ev.sclRise) begin
            nNack = ev.sdaNow;
          end else if (ev.sclFall) begin
            if (hostNack) begin
              nState = ST_IDLE;
            end else begin
              strobe.loadTx = 1'b1;
              nIdx   = idxNext;
              nState = ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      frameIdx <= '0;
      isRead   <= 1'b0;
      hostNack <= 1'b0;
    end else begin
      state    <= nState;
      bitCnt   <= nBit;
      frameIdx <= nIdx;
      isRead   <= nRead;
      hostNack <= nNack;
    end
  end

  assign sdaOe = (state == ST_SACK) | ((state == ST_TX) & ~txBit);

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3,
  parameter logic [NUM_BYTES*8-1:0] RESET_VALUE = {{(NUM_BYTES-1){8'hFF}}, 8'h00}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  output logic [NUM_BYTES*8-1:0] cfgBytes
);

  localparam int IDX_W = $clog2(NUM_BYTES + 3);

  busEvent_t        ev;
  dpStrobe_t        strobe;
  logic [IDX_W-1:0] frameIdx;
  logic [7:0]       rxByte;
  logic             txBit;

  i2c_cfg_dp #(
    .NUM_BYTES(NUM_BYTES),
    .SYNC_STAGES(2),
    .IDX_W(IDX_W),
    .RESET_VALUE(RESET_VALUE)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .strobe(strobe),
    .frameIdx(frameIdx),
    .ev(ev),
    .rxByte(rxByte),
    .txBit(txBit),
    .cfgBytes(cfgBytes)
  );

  i2c_cfg_ctrl #(
    .NUM_BYTES(NUM_BYTES),
    .IDX_W(IDX_W),
    .WR_ADDR(WR_ADDR),
    .RD_ADDR(RD_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .ev(ev),
    .rxByte(rxByte),
    .txBit(txBit),
    .strobe(strobe),
    .frameIdx(frameIdx),
    .sdaOe(sdaOe)
  );

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int NUM_BYTES = 6,
  parameter int IDX_W = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclFall,
  input logic                   startSeen,
  input logic                   stopSeen,
  input logic                   commitByte,
  input logic [IDX_W-1:0]       frameIdx,
  input logic                   sdaOe,
  input logic [NUM_BYTES*8-1:0] cfgBytes
);

  // R11
  drive_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> ($past(sclFall) || $past(startSeen) || $past(stopSeen)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitByte |=> $stable(cfgBytes));

  // R3
  dummy_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitByte && (frameIdx < IDX_W'(2))) |=> $stable(cfgBytes));

  // R6
  overflow_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitByte && (frameIdx >= IDX_W'(NUM_BYTES + 2))) |=> $stable(cfgBytes));

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaOe);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(
  .NUM_BYTES(NUM_BYTES),
  .IDX_W(IDX_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sclFall(ev.sclFall),
  .startSeen(ev.startSeen),
  .stopSeen(ev.stopSeen),
  .commitByte(strobe.commitByte),
  .frameIdx(frameIdx),
  .sdaOe(sdaOe),
  .cfgBytes(cfgBytes)
);

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;

  localparam int NB = 6;
  localparam int Q = 8;
  localparam logic [NB*8-1:0] DEF = 48'hFFFF_FFFF_FF00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic hostSda = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [NB*8-1:0] cfgBytes;

  int checks = 0;
  int errors = 0;
  int r11Bad = 0;
  bit done = 1'b0;
  logic [7:0] model [NB];
  logic [7:0] wrData [10];

  always #4 clk = ~clk;

  assign sdaLine = hostSda & ~sdaOe;

  i2c_cfg_slave u_i2c_cfg_slave (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclLine),
    .sdaIn(sdaLine),
    .sdaOe(sdaOe),
    .cfgBytes(cfgBytes)
  );

  // R11 monitor: drive must not move while SCL stays high
  logic oePrev = 1'b0;
  logic sclPrevB = 1'b1;
  always @(negedge clk) begin
    if (rstN && sclLine && sclPrevB && (sdaOe != oePrev)) r11Bad++;
    oePrev = sdaOe;
    sclPrevB = sclLine;
  end

  function automatic logic [NB*8-1:0] expCfg();
    logic [NB*8-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic slot(input bit drive, output bit seen);
    hostSda = drive;
    waitQ(1);
    sclLine = 1'b1;
    waitQ(1);
    seen = sdaLine;
    waitQ(1);
    sclLine = 1'b0;
    waitQ(1);
  endtask

  task automatic busStart();
    hostSda = 1'b1;
    waitQ(1);
    sclLine = 1'b1;
    waitQ(1);
    hostSda = 1'b0;
    waitQ(1);
    sclLine = 1'b0;
    waitQ(1);
  endtask

  task automatic busStop();
    hostSda = 1'b0;
    waitQ(1);
    sclLine = 1'b1;
    waitQ(1);
    hostSda = 1'b1;
    waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) slot(b[i], s);
    slot(1'b1, s);
    acked = !s;
  endtask

  task automatic sendPartial(input logic [7:0] b, input int n);
    bit s;
    for (int i = 0; i < n; i++) slot(b[7-i], s);
  endtask

  task automatic recvByte(input bit ack, output logic [7:0] b);
    bit s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      slot(1'b1, s);
      b = {b[6:0], s};
    end
    slot(!ack, s);
  endtask

  task automatic doWrite(input int n, input logic [7:0] cmd, input logic [7:0] cnt);
    bit a;
    busStart();
    sendByte(8'hD2, a);
    check(a, "R1", "write address ack", 48'(a), 48'd1);
    sendByte(cmd, a);
    check(a, "R3", "command byte ack", 48'(a), 48'd1);
    sendByte(cnt, a);
    check(a, "R3", "count byte ack", 48'(a), 48'd1);
    for (int i = 0; i < n; i++) begin
      sendByte(wrData[i], a);
      if (i < NB) begin
        check(a, "R4", "data byte ack", 48'(a), 48'd1);
        model[i] = wrData[i];
      end else begin
        check(a, "R6", "surplus byte ack", 48'(a), 48'd1);
      end
    end
    busStop();
    check(cfgBytes == expCfg(), "R5", "bank after write", cfgBytes, expCfg());
  endtask

  task automatic doRead(input int n);
    bit a;
    logic [7:0] b;
    logic [7:0] e;
    busStart();
    sendByte(8'hD3, a);
    check(a, "R1", "read address ack", 48'(a), 48'd1);
    recvByte(1'b1, b);
    check(b == 8'(NB), "R7", "count byte", 48'(b), 48'(NB));
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      e = (i < NB) ? model[i] : 8'hFF;
      check(b == e, "R8", "read data byte", 48'(b), 48'(e));
    end
    busStop();
    check(!sdaOe, "R8", "line released after read", 48'(sdaOe), 48'd0);
  endtask

  initial begin
    bit a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) model[i] = DEF[i*8 +: 8];
    repeat (10) @(negedge clk);
    // R10 reset state
    check(cfgBytes == DEF, "R10", "bank in reset", cfgBytes, DEF);
    check(!sdaOe, "R10", "no drive in reset", 48'(sdaOe), 48'd0);
    rstN = 1'b1;
    waitQ(2);

    // full write, dummy bytes must not land in byte 0 (R3, R4)
    wrData[0] = 8'h11; wrData[1] = 8'h22; wrData[2] = 8'h33;
    wrData[3] = 8'h44; wrData[4] = 8'h55; wrData[5] = 8'h66;
    doWrite(6, 8'hA5, 8'h5A);
    check(cfgBytes[7:0] == 8'h11, "R3", "byte0 not command", 48'(cfgBytes[7:0]), 48'h11);
    doRead(7);

    // short write then stop (R5)
    wrData[0] = 8'h9C; wrData[1] = 8'h00;
    doWrite(2, 8'h00, 8'hFF);

    // overrun write (R6)
    for (int i = 0; i < 8; i++) wrData[i] = 8'(8'hB0 + i);
    doWrite(8, 8'h01, 8'h06);
    doRead(6);

    // foreign addresses (R2)
    busStart();
    sendByte(8'hA0, a);
    check(!a, "R2", "foreign address no ack", 48'(a), 48'd0);
    sendByte(8'h00, a);
    check(!a, "R2", "no ack after foreign address", 48'(a), 48'd0);
    busStop();
    busStart();
    sendByte(8'hD0, a);
    check(!a, "R2", "near address no ack", 48'(a), 48'd0);
    busStop();
    check(cfgBytes == expCfg(), "R2", "bank untouched", cfgBytes, expCfg());

    // stop in the middle of a data byte (R9)
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    sendByte(8'h3C, a);
    model[0] = 8'h3C;
    sendPartial(8'h00, 4);
    busStop();
    check(cfgBytes == expCfg(), "R9", "partial byte dropped on stop", cfgBytes, expCfg());

    // repeated start in the middle of a data byte, then read (R9)
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    sendPartial(8'h00, 5);
    doRead(6);
    check(cfgBytes == expCfg(), "R9", "partial byte dropped on restart", cfgBytes, expCfg());

    // constrained random mix
    for (int it = 0; it < 14; it++) begin
      if ($urandom_range(0, 1) == 1) begin
        int n;
        n = $urandom_range(0, 8);
        for (int i = 0; i < 10; i++) wrData[i] = 8'($urandom);
        doWrite(n, 8'($urandom), 8'($urandom));
      end else begin
        doRead($urandom_range(1, 8));
      end
    end

    check(r11Bad == 0, "R11", "drive moved while SCL high", 48'(r11Bad), 48'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule